// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator CPU. Each cycle that `in_valid` is high it takes an operation code, the accumulator value, a second operand (a memory byte or the accumulator itself) and the incoming status byte. It computes one of nine operations: add with carry, OR, AND, exclusive OR, bit test, arithmetic shift left, logical shift right, and rotate left or right through carry.

One clock edge later it presents the result, a write strobe telling the CPU whether the result is to be written back, and the updated status byte. Only binary arithmetic is performed. Status bits an operation does not define leave the block as they came in.

The data width is a parameter with a default of 8. A second parameter selects either a ripple-carry chain or an inferred adder.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) forms the 9-bit sum in_acc + in_opnd + C, where C is status bit 0. The low 8 bits are the result and bit 8 is the new C. N (status bit 7) is result bit 7 and Z (status bit 1) is 1 exactly when the result is zero.
- R2: For op code 0, V (status bit 6) is 1 exactly when the result's sign bit differs from both in_acc bit 7 and in_opnd bit 7.
- R3: Op codes 1 (OR), 2 (AND) and 3 (XOR) write in_acc combined bitwise with in_opnd. They set N and Z from the result, and leave V and C equal to their incoming values.
- R4: Op code 5 (shift left) writes in_opnd shifted one place up with 0 entering bit 0, and C takes in_opnd bit 7. Op code 6 (shift right) writes in_opnd shifted one place down with 0 entering bit 7, and C takes in_opnd bit 0. Both set N and Z from the written value and keep V.
- R5: Op code 7 (rotate left) puts the incoming C into bit 0 and in_opnd bit 7 into C. Op code 8 (rotate right) puts the incoming C into bit 7 and in_opnd bit 0 into C. Both set N and Z from the written value and keep V.
- R6: Op code 4 (bit test) sets Z when (in_acc AND in_opnd) is zero, copies in_opnd bit 7 to N and bit 6 to V, and keeps C. It asserts no write strobe and leaves out_result unchanged.
- R7: For every operation, status bits 2 to 5 are passed through unchanged. Op codes 9 to 15 assert no write strobe, leave out_result unchanged and return the incoming status byte.
- R8: Results appear one cycle after the input: out_valid follows in_valid by one cycle. out_wr is high only together with out_valid. In a cycle without in_valid, out_result and out_status hold their values.
- R9: While rst_n is low, out_valid, out_wr, out_result and out_status are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| in_op | input | 4 | Operation code (0 add, 1 OR, 2 AND, 3 XOR, 4 bit test, 5 shift left, 6 shift right, 7 rotate left, 8 rotate right) |
| in_acc | input | W (8) | Accumulator value |
| in_opnd | input | W (8) | Second operand, or value to shift/rotate |
| in_status | input | 8 | Incoming status: N bit 7, V bit 6, Z bit 1, C bit 0, others pass |
| out_valid | output | 1 | Registered result valid |
| out_result | output | W (8) | Registered result |
| out_wr | output | 1 | Result is to be written back |
| out_status | output | 8 | Registered updated status |

## Verification
The assertions check several properties on every cycle:
- the one-cycle latency of out_valid;
- that the write strobe never appears without out_valid;
- that the pass-through status bits keep their values;
- that the logic operations keep V and C;
- that a bit test or an undefined code neither strobes nor disturbs the held result;
- that every written result's Z flag matches the result value.

The exact arithmetic is shown only by the bench's scenarios, which compare every output against a model fed with directed and randomized operands. That arithmetic covers carry and overflow at the sign boundaries, the bit that shifts and rotates move into carry, and the old carry entering at the opposite end. The same scenarios cover the reset values and the holding of outputs through idle cycles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   typedef enum logic [3:0] {
      OP_ADC = 4'd0,
      OP_OR  = 4'd1,
      OP_AND = 4'd2,
      OP_XOR = 4'd3,
      OP_BIT = 4'd4,
      OP_SHL = 4'd5,
      OP_SHR = 4'd6,
      OP_ROL = 4'd7,
      OP_ROR = 4'd8
   } alu_op_e;

   localparam int ST_C = 0;
   localparam int ST_Z = 1;
   localparam int ST_V = 6;
   localparam int ST_N = 7;
   localparam int ST_W = 8;
endpackage

// File: rtl/alu8_add.sv
module alu8_add #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   localparam int MSB = W - 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] carry;
         assign carry[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
         end
         assign cout = carry[W];
      end else begin : g_infer
         logic [W:0] wide;
         assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         assign sum  = wide[MSB:0];
         assign cout = wide[W];
      end
   endgenerate

   // signed overflow: result sign disagrees with both input signs
   assign ovf = (sum[MSB] ^ a[MSB]) & (sum[MSB] ^ b[MSB]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output logic         and_zero
);
   logic [W-1:0] conj;
   assign conj     = a & b;
   assign and_zero = (conj == '0);

   always_comb begin
      unique case (op)
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         default: res = conj;
      endcase
   end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] val,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout
);
   localparam int MSB = W - 1;

   logic left;
   logic fill;

   assign left = (op == OP_SHL) || (op == OP_ROL);
   assign fill = ((op == OP_ROL) || (op == OP_ROR)) ? cin : 1'b0;

   always_comb begin
      if (left) begin
         res  = {val[MSB-1:0], fill};
         cout = val[MSB];
      end else begin
         res  = {fill, val[MSB:1]};
         cout = val[0];
      end
   end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        in_op,
   input  logic [W-1:0]      in_acc,
   input  logic [W-1:0]      in_opnd,
   input  logic [ST_W-1:0]   in_status,
   output logic              out_valid,
   output logic [W-1:0]      out_result,
   output logic              out_wr,
   output logic [ST_W-1:0]   out_status
);
   localparam int MSB = W - 1;

   generate
      if (W < 4) begin : g_bad_width
         $error("alu8_core: W must be at least 4");
      end
   endgenerate

   alu_op_e op;
   assign op = alu_op_e'(in_op);

   logic [W-1:0] add_sum, log_res, sh_res;
   logic         add_c, add_v, and_z, sh_c;

   alu8_add #(.W(W), .RIPPLE(RIPPLE)) u_add (
      .a(in_acc), .b(in_opnd), .cin(in_status[ST_C]),
      .sum(add_sum), .cout(add_c), .ovf(add_v)
   );

   alu8_logic #(.W(W)) u_logic (
      .op(op), .a(in_acc), .b(in_opnd), .res(log_res), .and_zero(and_z)
   );

   alu8_shift #(.W(W)) u_shift (
      .op(op), .val(in_opnd), .cin(in_status[ST_C]), .res(sh_res), .cout(sh_c)
   );

   logic [W-1:0]    nxt_res;
   logic [ST_W-1:0] nxt_st;
   logic            nxt_wr;

   always_comb begin
      nxt_res = out_result;
      nxt_st  = in_status;
      nxt_wr  = 1'b0;
      case (op)
         OP_ADC: begin
            nxt_res        = add_sum;
            nxt_wr         = 1'b1;
            nxt_st[ST_C]   = add_c;
            nxt_st[ST_V]   = add_v;
         end
         OP_OR, OP_AND, OP_XOR: begin
            nxt_res = log_res;
            nxt_wr  = 1'b1;
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
            nxt_res      = sh_res;
            nxt_wr       = 1'b1;
            nxt_st[ST_C] = sh_c;
         end
         OP_BIT: begin
            nxt_st[ST_Z] = and_z;
            nxt_st[ST_N] = in_opnd[MSB];
            nxt_st[ST_V] = in_opnd[MSB-1];
         end
         default: ;
      endcase
      if (nxt_wr) begin
         nxt_st[ST_N] = nxt_res[MSB];
         nxt_st[ST_Z] = (nxt_res == '0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_wr     <= 1'b0;
         out_result <= '0;
         out_status <= '0;
      end else begin
         out_valid <= in_valid;
         out_wr    <= in_valid & nxt_wr;
         if (in_valid) begin
            out_result <= nxt_res;
            out_status <= nxt_st;
         end
      end
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
   AST_WR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> out_valid); // R8
   AST_PASS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_status[5:2] == $past(in_status[5:2])); // R7
   AST_LOGIC_KEEP_VC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_op == 4'd1 || in_op == 4'd2 || in_op == 4'd3))
      |=> (out_status[ST_V] == $past(in_status[ST_V])) &&
          (out_status[ST_C] == $past(in_status[ST_C]))); // R3
   AST_BIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 4'd4) |=> !out_wr && $stable(out_result)); // R6
   AST_UNDEF_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op > 4'd8)
      |=> !out_wr && $stable(out_result) && out_status == $past(in_status)); // R7
   AST_Z_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> out_status[ST_Z] == (out_result == '0)); // R1
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [3:0] in_op = '0;
   logic [W-1:0] in_acc = '0, in_opnd = '0;
   logic [7:0] in_status = '0;
   logic out_valid, out_wr;
   logic [W-1:0] out_result;
   logic [7:0] out_status;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu8_core u_alu8_core (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_acc(in_acc), .in_opnd(in_opnd), .in_status(in_status),
      .out_valid(out_valid), .out_result(out_result), .out_wr(out_wr),
      .out_status(out_status)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [16:0] expq[$];   // {wr, result, status}
   string       tagq[$];
   logic [W-1:0] last_res = '0;

   function automatic logic [16:0] model(input logic [3:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] st,
                                         input logic [7:0] prev);
      logic [8:0] s;
      logic [7:0] r;
      logic [7:0] o;
      logic w;
      o = st;
      r = prev;
      w = 1'b1;
      case (op)
         4'd0: begin
            s = {1'b0, a} + {1'b0, b} + {8'd0, st[0]};
            r = s[7:0];
            o[0] = s[8];
            o[6] = (a[7] == b[7]) && (r[7] != a[7]);
         end
         4'd1: r = a | b;
         4'd2: r = a & b;
         4'd3: r = a ^ b;
         4'd5: begin r = {b[6:0], 1'b0};  o[0] = b[7]; end
         4'd6: begin r = {1'b0, b[7:1]};  o[0] = b[0]; end
         4'd7: begin r = {b[6:0], st[0]}; o[0] = b[7]; end
         4'd8: begin r = {st[0], b[7:1]}; o[0] = b[0]; end
         4'd4: begin
            w = 1'b0;
            o[1] = ((a & b) == 8'd0);
            o[7] = b[7];
            o[6] = b[6];
         end
         default: w = 1'b0;
      endcase
      if (w) begin
         o[7] = r[7];
         o[1] = (r == 8'd0);
      end
      return {w, r, o};
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0: return "R1/R2 add";
         4'd1, 4'd2, 4'd3: return "R3 logic";
         4'd4: return "R6 bit test";
         4'd5, 4'd6: return "R4 shift";
         4'd7, 4'd8: return "R5 rotate";
         default: return "R7 undefined op";
      endcase
   endfunction

   task automatic send(input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] st);
      logic [16:0] e;
      @(negedge clk);
      in_valid  = 1'b1;
      in_op     = op;
      in_acc    = a;
      in_opnd   = b;
      in_status = st;
      e = model(op, a, b, st, last_res);
      last_res = e[15:8];
      expq.push_back(e);
      tagq.push_back(tag_of(op));
   endtask

   task automatic check(input bit ok, input string msg, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", msg, act, exp);
      end
   endtask

   // monitor: compare registered outputs against the scoreboard
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid && !done) begin
         if (expq.size() == 0) begin
            check(1'b0, "R8 unexpected out_valid", 32'(out_valid), 32'd0);
         end else begin
            logic [16:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check({out_wr, out_result, out_status} == e, t,
                  32'({out_wr, out_result, out_status}), 32'(e));
         end
      end
   end

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      in_op = 4'd0;
      in_status = 8'hFF;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(!out_valid && !out_wr, "R8 idle strobes", 32'({out_valid, out_wr}), 32'd0);
         check(out_result == last_res, "R8 idle hold result", 32'(out_result), 32'(last_res));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_wr == 1'b0, "R9 reset strobes",
            32'({out_valid, out_wr}), 32'd0);
      check(out_result == '0, "R9 reset result", 32'(out_result), 32'd0);
      check(out_status == '0, "R9 reset status", 32'(out_status), 32'd0);
      rst_n = 1'b1;

      // R1 / R2 add corners
      send(4'd0, 8'h7F, 8'h01, 8'h00);   // V set, N set
      send(4'd0, 8'h80, 8'h80, 8'h00);   // C, V, Z
      send(4'd0, 8'hFF, 8'h00, 8'h01);   // carry in wraps to zero
      send(4'd0, 8'h12, 8'h34, 8'h3D);   // pass bits set, no flags
      send(4'd0, 8'hFF, 8'hFF, 8'h01);   // negative, no overflow
      // R3 logic keeps V and C
      send(4'd1, 8'h00, 8'h00, 8'h41);
      send(4'd2, 8'hF0, 8'h0F, 8'hC1);
      send(4'd3, 8'hAA, 8'h55, 8'h02);
      // R4 shifts
      send(4'd5, 8'h00, 8'h80, 8'h00);
      send(4'd6, 8'h00, 8'h01, 8'h40);
      send(4'd5, 8'h00, 8'h41, 8'h01);
      // R5 rotates with carry in
      send(4'd7, 8'h00, 8'h80, 8'h01);
      send(4'd8, 8'h00, 8'h01, 8'h01);
      send(4'd8, 8'h00, 8'h02, 8'h00);
      // R6 bit test: no write, result held
      send(4'd4, 8'h0F, 8'hF0, 8'h01);
      send(4'd4, 8'hFF, 8'h40, 8'h80);
      // R7 undefined codes
      send(4'd9, 8'h11, 8'h22, 8'hA5);
      send(4'd15, 8'h33, 8'h44, 8'h5A);
      idle(3);

      for (int i = 0; i < 600; i++) begin
         logic [3:0] op;
         op = (i % 10 == 9) ? 4'(9 + $urandom_range(0, 6)) : 4'($urandom_range(0, 8));
         send(op, 8'($urandom), 8'($urandom), 8'($urandom));
         if (i % 97 == 96) idle(2);
      end
      idle(2);
      check(expq.size() == 0, "R8 all results delivered", 32'(expq.size()), 32'd0);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end
endmodule